// File: doc/BRIEF.md
# Bus-Access Clock Stall Controller

This block generates the two quadrature clocks, E and Q, for a processor that has no wait-state input. It also stretches any access that the processor makes to a slow asynchronous backplane. A decode input marks a backplane access. When that input is set, the controller lets the current clock phase finish and then freezes both clocks with E high and Q low. It opens the backplane buffers and, after a programmable setup delay, raises the address and data strobes. It then waits for the slave. The clocks run again as soon as the slave answers, either with a data acknowledge or with a transfer error.

The slave may never answer. This happens when it is faulty or when no slave sits at the address. For that case a watchdog counts reference-clock cycles from the start of the stall. When it expires, the watchdog ends the cycle itself, well before the processor's register contents are at risk. The same expiry raises a one-cycle timeout pulse and a sticky interrupt flag. The processor clears the flag once its interrupt handler has seen it.

Every output comes straight from a register. All timing is counted in cycles of one free-running reference clock.

Top module: `clkstall_ctrl`

## Requirements
- R1: With no access pending, E and Q run freely. Each clock is high for 2*PHASE_CYC and low for 2*PHASE_CYC reference cycles, and Q is a quarter period ahead of E: the states repeat (E,Q) = 00, 01, 11, 10. The two clocks never change on the same edge.
- R2: A stall begins only at the end of the E=1/Q=0 phase. The buffer enable rises while E=1 and Q=0.
- R3: E and Q hold their values for every cycle in which the buffer enable is high.
- R4: The address and data strobes rise exactly STB_DLY reference cycles after the buffer enable rises.
- R5: A response ends the strobes SYNC_STAGES+1 cycles after the response is driven. A response is dack_n low, terr_n low, or both. If the response and the watchdog expiry reach the sequencer on the same edge, the response wins and no timeout is raised.
- R6: With no response, the strobes fall WD_LIMIT cycles after the buffer enable rises. tmo_pulse is high for exactly that one cycle, and nmi_flag is set. The watchdog restarts from zero for every access.
- R7: The buffer enable never stays high for more than MAX_STALL reference cycles.
- R8: The strobes fall one cycle before the buffer enable. The buffer enable falls on the same edge on which the clocks resume at E=0, Q=0.
- R9: nmi_flag stays set until nmi_clr is high for a cycle. An access that ends with a response does not set it.
- R10: Synchronous reset forces E=0, Q=0, the buffer enable, both strobes, tmo_pulse and nmi_flag low. This holds even when reset arrives in the middle of a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Address decode: the processor is accessing the backplane |
| dack_n | input | 1 | Active-low data acknowledge from the slave, asynchronous |
| terr_n | input | 1 | Active-low transfer error from the slave, asynchronous |
| nmi_clr | input | 1 | Clears the sticky timeout flag |
| e_clk | output | 1 | Processor E clock |
| q_clk | output | 1 | Processor Q clock, a quarter period ahead of E |
| buf_en | output | 1 | Backplane address and data buffer enable |
| adr_stb | output | 1 | Address strobe, active high |
| dat_stb | output | 1 | Data strobe, active high |
| tmo_pulse | output | 1 | One-cycle pulse when the watchdog ends a cycle |
| nmi_flag | output | 1 | Sticky timeout flag to the non-maskable interrupt logic |

## Verification
A sequencer stuck in a waiting state shows up on the next access. The buffer enable stays high past MAX_STALL, and the E/Q pair stays frozen instead of passing through 00 again within four phases.

A delay counter or watchdog that is off by one moves the strobe edge or the timeout edge by one reference cycle. The bench counts both edges exactly.

A phase generator that freezes in the wrong phase is caught on the very first rise of the buffer enable. So is one that restarts from the wrong phase: either E/Q differs from 10 at that rise, or E/Q differs from 00 on the edge where the enable falls.

A lost or inverted timeout flag appears within a few cycles of the end of the access. The bench also runs the exact tie between response and expiry, which separates a design where the watchdog wins from one where the response wins.

// File: rtl/clkstall_pkg.sv
package clkstall_pkg;

  // Sequencer states of one stretched backplane cycle
  typedef enum logic [1:0] {
    ST_IDLE,    // clocks running
    ST_SETUP,   // buffers open, strobe setup delay counting
    ST_STROBE,  // strobes out, waiting for the slave
    ST_DONE     // strobes off, clocks resume, buffers close on exit
  } stall_state_e;

endpackage

// File: rtl/clkstall_phase_gen.sv
module clkstall_phase_gen #(
  parameter int unsigned PHASE_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic e_clk,
  output logic q_clk,
  output logic at_boundary
);

  localparam int unsigned DW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(PHASE_CYC - 1);

  logic [DW-1:0] div_q;

  // (E,Q) walks 00 -> 01 -> 11 -> 10 -> 00; hold freezes the whole state
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      e_clk <= 1'b0;
      q_clk <= 1'b0;
    end else if (!hold) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        e_clk <= q_clk;
        q_clk <= ~e_clk;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // Last reference cycle of the E-high / Q-low phase
  assign at_boundary = e_clk & ~q_clk & (div_q == DIV_LAST);

endmodule

// File: rtl/clkstall_sync.sv
module clkstall_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/clkstall_watchdog.sv
module clkstall_watchdog #(
  parameter int unsigned LIMIT = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // Counts while the stall is active; any idle cycle returns it to zero
  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/clkstall_ctrl.sv
module clkstall_ctrl
  import clkstall_pkg::*;
#(
  parameter int unsigned PHASE_CYC   = 25,
  parameter int unsigned STB_DLY     = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WD_LIMIT    = 1600,
  parameter int unsigned MAX_STALL   = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_sel,
  input  logic dack_n,
  input  logic terr_n,
  input  logic nmi_clr,
  output logic e_clk,
  output logic q_clk,
  output logic buf_en,
  output logic adr_stb,
  output logic dat_stb,
  output logic tmo_pulse,
  output logic nmi_flag
);

  localparam int unsigned DLY_W = $clog2(STB_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(STB_DLY - 1);

  generate
    if (STB_DLY < 1 || WD_LIMIT <= STB_DLY || WD_LIMIT + 1 > MAX_STALL) begin : g_bad_cfg
      $error("clkstall_ctrl: need 1 <= STB_DLY < WD_LIMIT and WD_LIMIT+1 <= MAX_STALL");
    end
  endgenerate

  stall_state_e   state_q;
  logic [DLY_W-1:0] dly_q;
  logic resp_raw, resp_s, at_bnd, entry, hold, wd_run, wd_exp;

  assign resp_raw = ~dack_n | ~terr_n;
  assign entry    = (state_q == ST_IDLE) && bus_sel && at_bnd;
  assign wd_run   = (state_q == ST_SETUP) || (state_q == ST_STROBE);
  assign hold     = entry || wd_run;

  clkstall_sync #(.STAGES(SYNC_STAGES)) i_resp_sync (
    .clk(clk), .rst(rst), .d(resp_raw), .q(resp_s)
  );

  clkstall_phase_gen #(.PHASE_CYC(PHASE_CYC)) i_phase (
    .clk(clk), .rst(rst), .hold(hold),
    .e_clk(e_clk), .q_clk(q_clk), .at_boundary(at_bnd)
  );

  clkstall_watchdog #(.LIMIT(WD_LIMIT)) i_wdog (
    .clk(clk), .rst(rst), .run(wd_run), .expire(wd_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      dly_q     <= '0;
      buf_en    <= 1'b0;
      adr_stb   <= 1'b0;
      dat_stb   <= 1'b0;
      tmo_pulse <= 1'b0;
      nmi_flag  <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (nmi_clr) nmi_flag <= 1'b0;   // a new timeout below overrides the clear
      unique case (state_q)
        ST_IDLE: begin
          if (entry) begin
            state_q <= ST_SETUP;
            buf_en  <= 1'b1;
            dly_q   <= '0;
          end
        end
        ST_SETUP: begin
          if (wd_exp) begin
            state_q   <= ST_DONE;
            tmo_pulse <= 1'b1;
            nmi_flag  <= 1'b1;
          end else if (dly_q == DLY_LAST) begin
            state_q <= ST_STROBE;
            adr_stb <= 1'b1;
            dat_stb <= 1'b1;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_STROBE: begin
          if (resp_s) begin
            state_q <= ST_DONE;
            adr_stb <= 1'b0;
            dat_stb <= 1'b0;
          end else if (wd_exp) begin
            state_q   <= ST_DONE;
            adr_stb   <= 1'b0;
            dat_stb   <= 1'b0;
            tmo_pulse <= 1'b1;
            nmi_flag  <= 1'b1;
          end
        end
        ST_DONE: begin
          state_q <= ST_IDLE;
          buf_en  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/clkstall_ctrl_chk.sv
module clkstall_ctrl_chk #(
  parameter int unsigned MAX_STALL = 2000
) (
  input logic clk,
  input logic rst,
  input logic nmi_clr,
  input logic e_clk,
  input logic q_clk,
  input logic buf_en,
  input logic adr_stb,
  input logic dat_stb,
  input logic tmo_pulse,
  input logic nmi_flag
);

  localparam int unsigned SW = $clog2(MAX_STALL + 2);
  localparam logic [SW-1:0] S_TOP = SW'(MAX_STALL + 1);

  logic [SW-1:0] stall_cnt;

  always_ff @(posedge clk) begin
    if (rst || !buf_en) stall_cnt <= '0;
    else if (stall_cnt != S_TOP) stall_cnt <= stall_cnt + 1'b1;
  end

  p_one_edge_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(e_clk) |-> $stable(q_clk));

  p_freeze_phase_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(buf_en) |-> (e_clk && !q_clk));

  p_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (buf_en && $past(buf_en)) |-> ($stable(e_clk) && $stable(q_clk)));

  p_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_stb) |-> $past(buf_en));

  p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    tmo_pulse |-> (nmi_flag && !adr_stb && buf_en));

  p_stall_bound_r7: assert property (@(posedge clk) disable iff (rst)
    stall_cnt <= SW'(MAX_STALL));

  p_stb_inside_r8: assert property (@(posedge clk) disable iff (rst)
    adr_stb |-> buf_en);

  p_stb_first_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(buf_en) |-> !$past(adr_stb));

  p_nmi_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (nmi_flag && !nmi_clr) |=> nmi_flag);

endmodule

bind clkstall_ctrl clkstall_ctrl_chk #(.MAX_STALL(MAX_STALL)) i_chk (
  .clk(clk), .rst(rst), .nmi_clr(nmi_clr), .e_clk(e_clk), .q_clk(q_clk),
  .buf_en(buf_en), .adr_stb(adr_stb), .dat_stb(dat_stb),
  .tmo_pulse(tmo_pulse), .nmi_flag(nmi_flag)
);

// File: tb/test_clkstall_ctrl.sv
`timescale 1ns/1ps
module test_clkstall_ctrl;

  localparam int PHASE_CYC = 2;
  localparam int STB_DLY   = 4;
  localparam int SYNC      = 2;
  localparam int WD_LIMIT  = 40;
  localparam int MAX_STALL = 50;
  localparam int WIN       = WD_LIMIT - STB_DLY;   // strobe-high cycles on timeout

  // Stimulus table: response kind (0 none, 1 dack, 2 terr, 3 both) and delay
  localparam int NV = 8;
  localparam int V_KIND [NV] = '{1, 2, 0, 0, 3, 1, 2, 1};
  localparam int V_DLY  [NV] = '{0, 5, 0, 0, 33, 34, 20, 9};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, dack_n = 1'b1, terr_n = 1'b1, nmi_clr = 1'b0;
  logic e_clk, q_clk, buf_en, adr_stb, dat_stb, tmo_pulse, nmi_flag;

  int pass_n = 0;
  int total_n = 0;

  always #2.5 clk = ~clk;

  clkstall_ctrl #(
    .PHASE_CYC(PHASE_CYC), .STB_DLY(STB_DLY), .SYNC_STAGES(SYNC),
    .WD_LIMIT(WD_LIMIT), .MAX_STALL(MAX_STALL)
  ) i_clkstall_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .dack_n(dack_n), .terr_n(terr_n),
    .nmi_clr(nmi_clr), .e_clk(e_clk), .q_clk(q_clk), .buf_en(buf_en),
    .adr_stb(adr_stb), .dat_stb(dat_stb), .tmo_pulse(tmo_pulse), .nmi_flag(nmi_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total_n++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk({e_clk, q_clk, buf_en, adr_stb, dat_stb, tmo_pulse, nmi_flag} == 7'b0,
        "R10 reset state", {e_clk, q_clk, buf_en, adr_stb, nmi_flag}, 0);

    // R1: free-running clocks, period and quadrature
    n = 0;
    while (!(e_clk == 1'b0 && q_clk == 1'b1) && n < 50) begin @(negedge clk); n++; end
    @(negedge clk); while (!e_clk && n < 100) begin @(negedge clk); n++; end
    chk(q_clk == 1'b1, "R1 Q leads E at E rise", q_clk, 1);
    n = 0;
    @(negedge clk); n++;
    while (!(e_clk && q_clk && n > 1) && n < 100) begin
      if (!e_clk) begin
        while (!e_clk && n < 100) begin @(negedge clk); n++; end
        break;
      end
      @(negedge clk); n++;
    end
    chk(n == 4 * PHASE_CYC, "R1 E period", n, 4 * PHASE_CYC);

    // Table-driven accesses
    for (int v = 0; v < NV; v++) begin
      bit frz_ok, exp_tmo;
      int exp_lat, n_stb, n_lat;
      exp_tmo = (V_KIND[v] == 0) || (V_DLY[v] + SYNC + 1 > WIN);
      exp_lat = exp_tmo ? WIN : V_DLY[v] + SYNC + 1;
      @(negedge clk); bus_sel = 1'b1;
      n = 0;
      while (!buf_en && n < 100) begin @(negedge clk); n++; end
      chk(buf_en && e_clk && !q_clk, "R2 freeze phase E=1 Q=0", {e_clk, q_clk}, 2);
      frz_ok = 1'b1; n_stb = 0;
      while (!adr_stb && n_stb < 100) begin
        @(negedge clk); n_stb++;
        if (!(e_clk && !q_clk)) frz_ok = 1'b0;
      end
      chk(n_stb == STB_DLY && dat_stb, "R4 strobe setup delay", n_stb, STB_DLY);
      n_lat = 0;
      while (adr_stb && n_lat < 200) begin
        if (V_KIND[v] != 0 && n_lat == V_DLY[v]) begin
          dack_n = ~V_KIND[v][0];
          terr_n = ~V_KIND[v][1];
        end
        @(negedge clk); n_lat++;
        if (!(e_clk && !q_clk)) frz_ok = 1'b0;
      end
      chk(n_lat == exp_lat, exp_tmo ? "R6 timeout strobe length" : "R5 response latency",
          n_lat, exp_lat);
      chk(tmo_pulse == exp_tmo, "R6 timeout pulse", tmo_pulse, exp_tmo);
      chk(buf_en && !dat_stb, "R8 strobes off before enable", buf_en, 1);
      chk(n_stb + n_lat + 1 <= MAX_STALL, "R7 stall bound", n_stb + n_lat + 1, MAX_STALL);
      @(negedge clk);
      chk(!buf_en && !e_clk && !q_clk && !tmo_pulse, "R8 resume at E=0 Q=0 with enable low",
          {buf_en, e_clk, q_clk, tmo_pulse}, 0);
      chk(frz_ok, "R3 clocks frozen during stall", frz_ok, 1);
      dack_n = 1'b1; terr_n = 1'b1; bus_sel = 1'b0;
      repeat (3) @(negedge clk);
      chk(nmi_flag == exp_tmo, "R9 flag held until cleared", nmi_flag, exp_tmo);
      nmi_clr = 1'b1; @(negedge clk); nmi_clr = 1'b0;
      chk(!nmi_flag, "R9 flag cleared", nmi_flag, 0);
      repeat (5) @(negedge clk);
    end

    // R10: reset in the middle of a stall
    bus_sel = 1'b1;
    n = 0;
    while (!adr_stb && n < 100) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    rst = 1'b1; bus_sel = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk({e_clk, q_clk, buf_en, adr_stb, dat_stb, tmo_pulse, nmi_flag} == 7'b0,
        "R10 reset mid-stall", {e_clk, q_clk, buf_en, adr_stb}, 0);
    repeat (4 * PHASE_CYC + 2) @(negedge clk);
    chk(!buf_en, "R10 no stall after reset with decode low", buf_en, 0);

    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

endmodule